// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a down-counting interval timer reached through a small word-addressed register bus with 16-bit data. Software writes a 32-bit period in two 16-bit halves, chooses whether the counter reloads by itself or stops after one interval, and starts or stops it with two separate strobe bits. When the count passes through zero, a timeout flag sets. That flag, gated by an interrupt-enable bit, drives one level-sensitive interrupt line. A status write clears the flag.

To measure time inside an interval, software writes any value to either capture register. The full 32-bit live count is frozen into both halves at once. Software then reads the two halves and subtracts the joined value from the period. Reads are combinational from the addressed register. Writes take effect at the next rising clock edge. While running, the counter takes the values period, period-1, ..., 0 and then reloads, so one interval lasts period+1 cycles.

Top module: `itmr_top`

## Requirements
- R1: The register word addresses are: 0 status, 1 control, 2 period bits 15:0, 3 period bits 31:16, 4 capture bits 15:0, 5 capture bits 31:16. Reading a period half returns the last value written to it. Any other address reads zero.
- R2: After reset the counter is stopped, the interrupt enable, the reload-mode bit and the timeout flag are 0, the period and the count are all ones, the capture register is 0 and the interrupt output is low.
- R3: A control write stores bit 0 as the interrupt enable and bit 1 as the reload mode (1 = continuous). Bit 3 set stops the counter. Bit 2 set, with bit 3 clear, starts it. When both bits are set, stop wins. A control read returns {reload mode, enable} in bits 1:0. Status bit 1 reads 1 while the counter runs.
- R4: While running and not at zero, the count drops by exactly one per clock cycle.
- R5: A running counter at zero sets the timeout flag (status bit 0) at the next edge. In continuous mode it reloads the period and keeps running.
- R6: In one-shot mode (bit 1 = 0), a running counter at zero reloads the period and stops.
- R7: A write to either period half updates that half, stops the counter and loads the whole new period into the count in the same edge.
- R8: A write of any data to address 4 or 5 copies the full 32-bit count, as it stood before that edge, into both capture halves.
- R9: A write to status clears the timeout flag. If a timeout occurs in the same cycle, the flag stays set.
- R10: The interrupt output is high exactly when the timeout flag and the interrupt enable are both 1.
- R11: A start on a running counter leaves the count sequence undisturbed and only updates the enable and mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 3 | Register word address |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data of the addressed register (combinational) |
| irqOut | output | 1 | Level interrupt: timeout flag AND enable |

## Verification
Two pairs of events can collide in a single cycle: a timeout and a status-clear write, and a timeout and a control write that carries start or stop. The bench uses its reference model to find the exact cycle in which the running count sits at zero, and issues the write in that cycle. The expected flag and run state then come from the stated priorities: the timeout wins over the clear, and the strobes override the one-shot stop. A period write that lands on a zero count is also provoked. It must win over both the reload and the timeout.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_CTRL   = 1;
  localparam int unsigned ADDR_PER_LO = 2;
  localparam int unsigned ADDR_PER_HI = 3;
  localparam int unsigned ADDR_CAP_LO = 4;
  localparam int unsigned ADDR_CAP_HI = 5;

  localparam int unsigned CTRL_IE_BIT    = 0;
  localparam int unsigned CTRL_CONT_BIT  = 1;
  localparam int unsigned CTRL_START_BIT = 2;
  localparam int unsigned CTRL_STOP_BIT  = 3;
  localparam int unsigned CTRL_W         = 4;

  typedef struct packed {
    logic perLoWr;
    logic perHiWr;
    logic step;
    logic capTake;
  } dpStrobes_t;
endpackage

// File: rtl/itmr_control.sv
module itmr_control
  import itmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CTRL_W-1:0] ctrlBits,
  input  logic              countZero,
  output dpStrobes_t        strb,
  output logic              runFlag,
  output logic              toFlag,
  output logic              ieBit,
  output logic              contBit
);
  logic wrStatus, wrCtrl, wrPerLo, wrPerHi, wrCap, perWr, terminal;

  assign wrStatus = busWrEn && (busAddr == ADDR_W'(ADDR_STATUS));
  assign wrCtrl   = busWrEn && (busAddr == ADDR_W'(ADDR_CTRL));
  assign wrPerLo  = busWrEn && (busAddr == ADDR_W'(ADDR_PER_LO));
  assign wrPerHi  = busWrEn && (busAddr == ADDR_W'(ADDR_PER_HI));
  assign wrCap    = busWrEn && ((busAddr == ADDR_W'(ADDR_CAP_LO)) ||
                                (busAddr == ADDR_W'(ADDR_CAP_HI)));
  assign perWr    = wrPerLo || wrPerHi;
  // a period write pre-empts the counter in this cycle, so no timeout either
  assign terminal = runFlag && countZero && !perWr;

  always_comb begin
    strb.perLoWr = wrPerLo;
    strb.perHiWr = wrPerHi;
    strb.step    = runFlag && !perWr;
    strb.capTake = wrCap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runFlag <= 1'b0;
      toFlag  <= 1'b0;
      ieBit   <= 1'b0;
      contBit <= 1'b0;
    end else begin
      if (terminal)      toFlag <= 1'b1;
      else if (wrStatus) toFlag <= 1'b0;

      if (perWr)                                   runFlag <= 1'b0;
      else if (wrCtrl && ctrlBits[CTRL_STOP_BIT])  runFlag <= 1'b0;
      else if (wrCtrl && ctrlBits[CTRL_START_BIT]) runFlag <= 1'b1;
      else if (terminal && !contBit)               runFlag <= 1'b0;

      if (wrCtrl) begin
        ieBit   <= ctrlBits[CTRL_IE_BIT];
        contBit <= ctrlBits[CTRL_CONT_BIT];
      end
    end
  end
endmodule

// File: rtl/itmr_datapath.sv
module itmr_datapath
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  periodVal,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  capVal,
  output logic              countZero
);
  logic [CNT_W-1:0] nextPeriod;

  assign countZero = (countVal == '0);

  always_comb begin
    nextPeriod = periodVal;
    if (strb.perLoWr) nextPeriod[DATA_W-1:0]     = wrData;
    if (strb.perHiWr) nextPeriod[CNT_W-1:DATA_W] = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodVal <= '1;
      countVal  <= '1;
      capVal    <= '0;
    end else begin
      periodVal <= nextPeriod;
      if (strb.perLoWr || strb.perHiWr) countVal <= nextPeriod;
      else if (strb.step)               countVal <= countZero ? periodVal : countVal - CNT_W'(1);
      if (strb.capTake) capVal <= countVal;
    end
  end
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  dpStrobes_t       strb;
  logic             runFlag, toFlag, ieBit, contBit, countZero;
  logic [CNT_W-1:0] periodVal, countVal, capVal;

  itmr_control #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .ctrlBits(busWrData[CTRL_W-1:0]), .countZero(countZero), .strb(strb),
    .runFlag(runFlag), .toFlag(toFlag), .ieBit(ieBit), .contBit(contBit)
  );

  itmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .periodVal(periodVal), .countVal(countVal), .capVal(capVal),
    .countZero(countZero)
  );

  assign irqOut = toFlag && ieBit;

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(ADDR_STATUS): busRdData[1:0] = {runFlag, toFlag};
      ADDR_W'(ADDR_CTRL):   busRdData[1:0] = {contBit, ieBit};
      ADDR_W'(ADDR_PER_LO): busRdData = periodVal[DATA_W-1:0];
      ADDR_W'(ADDR_PER_HI): busRdData = periodVal[CNT_W-1:DATA_W];
      ADDR_W'(ADDR_CAP_LO): busRdData = capVal[DATA_W-1:0];
      ADDR_W'(ADDR_CAP_HI): busRdData = capVal[CNT_W-1:DATA_W];
      default:              busRdData = '0;
    endcase
  end
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              wrStop,
  input logic              irqOut,
  input logic              runFlag,
  input logic              toFlag,
  input logic              ieBit,
  input logic              contBit,
  input logic [CNT_W-1:0]  countVal
);
  logic perWrC, ctrlWrC, statWrC, atZero;
  assign perWrC  = busWrEn && (busAddr == ADDR_W'(2) || busAddr == ADDR_W'(3));
  assign ctrlWrC = busWrEn && (busAddr == ADDR_W'(1));
  assign statWrC = busWrEn && (busAddr == ADDR_W'(0));
  assign atZero  = runFlag && (countVal == '0) && !perWrC;

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrC && wrStop |=> !runFlag); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    runFlag && (countVal != '0) && !perWrC |=> countVal == $past(countVal) - CNT_W'(1)); // R4
  AST_TIMEOUT_SET: assert property (@(posedge clk) disable iff (!rstN)
    atZero |=> toFlag); // R5
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    atZero && !contBit && !ctrlWrC |=> !runFlag); // R6
  AST_PERIOD_HALT: assert property (@(posedge clk) disable iff (!rstN)
    perWrC |=> !runFlag); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    statWrC && !atZero |=> !toFlag); // R9
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !ieBit |-> !irqOut); // R10
endmodule

bind itmr_top itmr_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .wrStop(busWrData[3]), .irqOut(irqOut), .runFlag(runFlag), .toFlag(toFlag),
  .ieBit(ieBit), .contBit(contBit), .countVal(countVal)
);

// File: tb/test_itmr_top.sv
`timescale 1ns/1ps
module test_itmr_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  bit          mRun, mTo, mIe, mCont;
  logic [31:0] mPer, mCnt, mCap;

  always #2 clk = ~clk;

  itmr_top i_itmr_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return {14'd0, mRun, mTo};
      3'd1: return {14'd0, mCont, mIe};
      3'd2: return mPer[15:0];
      3'd3: return mPer[31:16];
      3'd4: return mCap[15:0];
      3'd5: return mCap[31:16];
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] a);
    case (a)
      3'd0: return "R5/R9 status";
      3'd1: return "R3 control";
      3'd2, 3'd3: return "R1/R7 period";
      3'd4, 3'd5: return "R8 capture";
      default: return "R1 unmapped";
    endcase
  endfunction

  task automatic modelReset();
    mRun = 0; mTo = 0; mIe = 0; mCont = 0;
    mPer = '1; mCnt = '1; mCap = '0;
  endtask

  task automatic modelStep(input bit wr, input logic [2:0] a, input logic [15:0] d);
    bit perWr, term, nRun, nTo;
    logic [31:0] nPer, nCnt;
    perWr = wr && (a == 3'd2 || a == 3'd3);
    term  = mRun && (mCnt == 0) && !perWr;
    nPer = mPer;
    if (wr && a == 3'd2) nPer[15:0]  = d;
    if (wr && a == 3'd3) nPer[31:16] = d;
    nCnt = mCnt;
    if (perWr) nCnt = nPer;
    else if (mRun) nCnt = (mCnt == 0) ? mPer : mCnt - 1;
    nTo = mTo;
    if (wr && a == 3'd0) nTo = 0;
    if (term) nTo = 1;
    nRun = mRun;
    if (term && !mCont) nRun = 0;
    if (wr && a == 3'd1) begin
      if (d[3]) nRun = 0;
      else if (d[2]) nRun = 1;
    end
    if (perWr) nRun = 0;
    if (wr && a == 3'd1) begin mIe = d[0]; mCont = d[1]; end
    if (wr && (a == 3'd4 || a == 3'd5)) mCap = mCnt;
    mPer = nPer; mCnt = nCnt; mRun = nRun; mTo = nTo;
  endtask

  // one bus cycle: drive, compare combinational outputs against the model, advance
  task automatic cyc(input bit wr, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busWrEn = wr; busAddr = a; busWrData = d;
    #0.5;
    chk(busRdData == modelRead(a), tagOf(a), {16'd0, busRdData}, {16'd0, modelRead(a)});
    chk(irqOut == (mTo && mIe), "R10 irq", {31'd0, irqOut}, {31'd0, mTo && mIe});
    @(posedge clk);
    modelStep(wr, a, d);
  endtask

  // read with an additional literal expectation
  task automatic rdExp(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    busWrEn = 0; busAddr = a; busWrData = 16'h0;
    #0.5;
    chk(busRdData == exp, req, {16'd0, busRdData}, {16'd0, exp});
    @(posedge clk);
    modelStep(0, a, 16'h0);
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    for (int i = 0; i < n; i++) cyc(0, a, 16'h0);
  endtask

  task automatic waitZero();
    int guard = 0;
    while (!(mRun && mCnt == 0) && guard < 100000) begin
      cyc(0, 3'd0, 16'h0);
      guard++;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R2 reset state
    rdExp(3'd0, 16'h0000, "R2 status after reset");
    rdExp(3'd1, 16'h0000, "R2 control after reset");
    rdExp(3'd2, 16'hFFFF, "R2 period lo after reset");
    rdExp(3'd3, 16'hFFFF, "R2 period hi after reset");
    rdExp(3'd4, 16'h0000, "R2 capture after reset");
    chk(irqOut == 1'b0, "R2 irq after reset", {31'd0, irqOut}, 32'd0);
    rdExp(3'd7, 16'h0000, "R1 unmapped address");

    // R1 period programming
    cyc(1, 3'd2, 16'd5);
    cyc(1, 3'd3, 16'd0);
    rdExp(3'd2, 16'd5, "R1 period lo readback");
    rdExp(3'd3, 16'd0, "R1 period hi readback");

    // continuous, enabled, start
    cyc(1, 3'd1, 16'h0007);
    rdExp(3'd0, 16'h0002, "R3 running after start");
    cyc(1, 3'd4, 16'hABCD);
    rdExp(3'd5, 16'h0000, "R8 capture hi");
    cyc(0, 3'd4, 16'h0);
    idle(14, 3'd0);
    chk(irqOut == 1'b1, "R10 irq with enable and flag", {31'd0, irqOut}, 32'd1);
    cyc(1, 3'd0, 16'h1234);
    idle(3, 3'd0);

    // R9 collision: clear in the timeout cycle
    waitZero();
    cyc(1, 3'd0, 16'h0);
    rdExp(3'd0, 16'h0003, "R9 timeout beats clear");

    // R11 start while running: count undisturbed, enable cleared
    cyc(1, 3'd1, 16'h0006);
    idle(2, 3'd4);
    cyc(1, 3'd5, 16'h0);
    idle(2, 3'd5);
    chk(irqOut == 1'b0, "R11 irq masked after mode update", {31'd0, irqOut}, 32'd0);

    // R6 one-shot
    cyc(1, 3'd1, 16'h0001);
    waitZero();
    idle(3, 3'd0);
    rdExp(3'd0, 16'h0001, "R6 stopped after one-shot");

    // R3 start and stop together
    cyc(1, 3'd1, 16'h000E);
    rdExp(3'd0, 16'h0001, "R3 stop beats start");
    cyc(1, 3'd1, 16'h0006);
    idle(4, 3'd0);

    // collision: stop strobe and start strobe on timeout cycles
    waitZero();
    cyc(1, 3'd1, 16'h000A);
    rdExp(3'd0, 16'h0001, "R3 stop at timeout");
    cyc(1, 3'd1, 16'h0005);
    waitZero();
    cyc(1, 3'd1, 16'h0005);
    rdExp(3'd0, 16'h0003, "R3 start overrides one-shot stop");

    // R7 period write while running, including at zero
    cyc(1, 3'd1, 16'h0006);
    idle(2, 3'd0);
    cyc(1, 3'd3, 16'h0001);
    rdExp(3'd0, 16'h0001, "R7 halted by period write");
    cyc(1, 3'd4, 16'h0);
    rdExp(3'd5, 16'h0001, "R7 capture hi of new period");
    rdExp(3'd4, 16'h0005, "R7 capture lo of new period");
    cyc(1, 3'd3, 16'h0000);
    cyc(1, 3'd0, 16'h0);
    cyc(1, 3'd1, 16'h0007);
    waitZero();
    cyc(1, 3'd2, 16'h0009);
    rdExp(3'd0, 16'h0000, "R7 period write beats timeout");

    // R4 long run with captures
    cyc(1, 3'd1, 16'h0006);
    for (int i = 0; i < 6; i++) begin
      cyc(1, 3'd4, 16'h0);
      cyc(0, 3'd4, 16'h0);
    end
    idle(20, 3'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule